// File: doc/BRIEF.md
# Streaming Fragment Formatter with Latency Stamp

This block wraps the data one board produces for a single triggered event into a fragment for a 32-bit point-to-point link. A trigger-accept strobe opens an event. The block then writes two header words, forwards each incoming data word as soon as it arrives, and closes the fragment with a trailer word once the upstream logic marks the event as done. The header holds no word count, so nothing has to be collected before the first word goes out. In its place the header carries a latency stamp, taken from a free-running timer that restarts on every accept. It also carries the latency that was measured for the previous event.

A bunch-crossing counter sits inside the block and is sampled into every first header word. The trailer reports how many data words were actually forwarded, together with error flags. The outgoing stream passes through a small elastic queue and uses a valid/ready handshake. A control flag marks header and trailer words. While the link applies back-pressure, the queue holds its words. Data that arrives while the queue is full is dropped, and the drop is flagged in the trailer.

Top module: `stream_frag_fmt`

## Requirements
- R1: First header word layout, from bit 31 down: format version [31:24], source [23:20], region [19:18], zero [17:10], bunch count [9:2], buffer number [1:0].
- R2: Second header word is {previous latency[31:16], current latency[15:0]}. The timer reads 0 in the cycle after the accept and counts one per clock. Header 2 is written two clocks after the accept, so its current field is 1.
- R3: After reset, valid_o is low. With ready_i high and no backlog, a data word captured at a clock edge shows on dout_o with ctrl_o=0 in the following cycle. Words keep their order.
- R4: Trailer word is {forwarded word count[31:16], err_i[14:0] at [15:1], overflow at [0]}. err_i is sampled when the trailer is written.
- R5: Previous latency is the timer value at the prior event's trailer write. It is 0 after reset.
- R6: ctrl_o is 1 on both header words and on the trailer, and 0 on data words.
- R7: While valid_o is high and ready_i is low, dout_o and ctrl_o hold. No queued word is lost.
- R8: A data word that arrives while the queue is full is dropped. It is not counted, and it sets trailer bit 0. The next accept clears that bit.
- R9: The latency timer saturates at 0xFFFF.
- R10: The bunch counter adds one per bx_i strobe, wraps modulo 256, and is sampled into header 1.
- R11: A data word and done_i in the same cycle: the word is forwarded and counted, and the trailer follows it directly.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| accept_i | input | 1 | Trigger accept; opens an event when idle |
| bx_i | input | 1 | Bunch-crossing strobe |
| done_i | input | 1 | Last input of the event |
| din_valid_i | input | 1 | Data word valid |
| din_i | input | 32 | Data word |
| fmt_ver_i | input | 8 | Format version field |
| src_id_i | input | 4 | Data source field |
| region_i | input | 2 | Region field |
| buf_num_i | input | 2 | Buffer number field |
| err_i | input | 15 | External error conditions |
| ready_i | input | 1 | Link can take a word |
| valid_o | output | 1 | dout_o holds a word |
| ctrl_o | output | 1 | Word is a header or trailer |
| dout_o | output | 32 | Output word |

## Verification
Two functions can fall in the same cycle. The first is closing the event while a final data word arrives: the bench raises done_i together with the last valid word, then checks that the trailer count includes that word and that the trailer follows it directly. The second is back-pressure while input keeps coming: the bench holds ready_i low through the headers and four data words. It checks that the held output word stays stable, that exactly the two words that fit reach the link, and that the trailer shows a count of two with the overflow bit set. The bench also checks that the overflow bit is clear again in the next event.

// File: rtl/frag_pkg.sv
package frag_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR1,
    ST_HDR2,
    ST_DATA,
    ST_TRL
  } fmt_state_e;

  typedef struct packed {
    logic              ctrl;
    logic [WORD_W-1:0] data;
  } link_word_t;
endpackage

// File: rtl/lat_timer.sv
module lat_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_o <= '0;
    else if (clr_i)        cnt_o <= '0;
    else if (cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end

  AST_TIMER_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX && !clr_i) |=> cnt_o == MAX); // R9
endmodule

// File: rtl/bunch_ctr.sv
module bunch_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bx_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (bx_i) cnt_o <= cnt_o + 1'b1;
  end

  AST_BX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bx_i |=> cnt_o == W'($past(cnt_o) + 1'b1)); // R10
endmodule

// File: rtl/frag_fifo.sv
module frag_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 33
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         valid_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign dout_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pop_i) |=> (valid_o && $stable(dout_o))); // R7
endmodule

// File: rtl/stream_frag_fmt.sv
module stream_frag_fmt
  import frag_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned LAT_W      = 16,
  parameter int unsigned BX_W       = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        accept_i,
  input  logic        bx_i,
  input  logic        done_i,
  input  logic        din_valid_i,
  input  logic [31:0] din_i,
  input  logic [7:0]  fmt_ver_i,
  input  logic [3:0]  src_id_i,
  input  logic [1:0]  region_i,
  input  logic [1:0]  buf_num_i,
  input  logic [14:0] err_i,
  input  logic        ready_i,
  output logic        valid_o,
  output logic        ctrl_o,
  output logic [31:0] dout_o
);
  localparam int unsigned SIZE_W = WORD_W / 2;
  localparam int unsigned LW_W   = $bits(link_word_t);

  fmt_state_e        state_q, state_d;
  logic [LAT_W-1:0]  lat_cnt, prev_lat_q;
  logic [BX_W-1:0]   bx_cnt;
  logic [SIZE_W-1:0] size_q;
  logic              ovf_q;
  logic              timer_clr, q_full, push;
  link_word_t        push_word, head_word;
  logic [LW_W-1:0]   head_raw;

  assign timer_clr = accept_i && (state_q == ST_IDLE);

  lat_timer #(.W(LAT_W)) i_lat_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (timer_clr),
    .cnt_o (lat_cnt)
  );

  bunch_ctr #(.W(BX_W)) i_bunch_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bx_i  (bx_i),
    .cnt_o (bx_cnt)
  );

  always_comb begin
    state_d   = state_q;
    push      = 1'b0;
    push_word = '0;
    unique case (state_q)
      ST_IDLE: if (accept_i) state_d = ST_HDR1;
      ST_HDR1: if (!q_full) begin
        push      = 1'b1;
        push_word = '{ctrl: 1'b1,
                      data: {fmt_ver_i, src_id_i, region_i, 8'h00, bx_cnt, buf_num_i}};
        state_d   = ST_HDR2;
      end
      ST_HDR2: if (!q_full) begin
        push      = 1'b1;
        push_word = '{ctrl: 1'b1, data: {prev_lat_q, lat_cnt}};
        state_d   = ST_DATA;
      end
      ST_DATA: begin
        if (din_valid_i && !q_full) begin
          push      = 1'b1;
          push_word = '{ctrl: 1'b0, data: din_i};
        end
        if (done_i) state_d = ST_TRL;
      end
      ST_TRL: if (!q_full) begin
        push      = 1'b1;
        push_word = '{ctrl: 1'b1, data: {size_q, err_i, ovf_q}};
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      size_q     <= '0;
      ovf_q      <= 1'b0;
      prev_lat_q <= '0;
    end else begin
      state_q <= state_d;
      if (timer_clr) begin
        size_q <= '0;
        ovf_q  <= 1'b0;
      end else if (state_q == ST_DATA && din_valid_i) begin
        if (q_full) ovf_q  <= 1'b1;  // word dropped
        else        size_q <= size_q + 1'b1;
      end
      if (state_q == ST_TRL && !q_full) prev_lat_q <= lat_cnt;
    end
  end

  frag_fifo #(.DEPTH(FIFO_DEPTH), .W(LW_W)) i_frag_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .din_i  (push_word),
    .pop_i  (ready_i),
    .dout_o (head_raw),
    .valid_o(valid_o),
    .full_o (q_full)
  );

  assign head_word = link_word_t'(head_raw);
  assign ctrl_o    = head_word.ctrl;
  assign dout_o    = head_word.data;

  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(din_valid_i && q_full)); // R8
  AST_DROP_NOCOUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && din_valid_i && q_full) |=> $stable(size_q)); // R8
  AST_HDR_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HDR1 && !q_full) |=> state_q == ST_HDR2); // R1
  AST_DONE_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && done_i) |=> state_q == ST_TRL); // R11
endmodule

// File: tb/test_stream_frag_fmt.sv
module test_stream_frag_fmt;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, accept, bx, done, din_valid, ready;
  logic [31:0] din;
  logic [7:0]  fmt_ver;
  logic [3:0]  src_id;
  logic [1:0]  region, buf_num;
  logic [14:0] err;
  logic        valid_o, ctrl_o;
  logic [31:0] dout_o;

  int n_chk = 0, n_fail = 0, bunch_exp = 0;
  logic [15:0] prev_exp = 16'd0;
  logic [32:0] got[$];
  bit finished = 1'b0;

  stream_frag_fmt i_stream_frag_fmt (
    .clk_i(clk), .rst_ni(rst_n), .accept_i(accept), .bx_i(bx), .done_i(done),
    .din_valid_i(din_valid), .din_i(din), .fmt_ver_i(fmt_ver), .src_id_i(src_id),
    .region_i(region), .buf_num_i(buf_num), .err_i(err), .ready_i(ready),
    .valid_o(valid_o), .ctrl_o(ctrl_o), .dout_o(dout_o)
  );

  always @(negedge clk) begin
    #2;
    if (rst_n && valid_o && ready) got.push_back({ctrl_o, dout_o});
  end

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] hdr1();
    return {1'b1, fmt_ver, src_id, region, 8'h00, 8'(bunch_exp), buf_num};
  endfunction

  task automatic pulse_bx(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk) bx = 1'b1;
      @(negedge clk) bx = 1'b0;
    end
    bunch_exp = (bunch_exp + k) % 256;
  endtask

  task automatic open_event();
    got.delete();
    @(negedge clk) accept = 1'b1;
    @(negedge clk) accept = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // n words, gap idle cycles between words, tail idle cycles before a separate done
  task automatic run_event(input int n, input int gap, input int tail,
                           input bit done_last, input logic [14:0] e, input string tag);
    int p = 0;
    int lat;
    logic [31:0] w[$];
    open_event();
    err = e;
    for (int i = 0; i < n; i++) begin
      w.push_back(32'hA500_0000 + 32'(i) + (32'(bunch_exp) << 12));
      din_valid = 1'b1;
      din = w[i];
      done = done_last && (i == n - 1);
      @(negedge clk);
      p++;
      din_valid = 1'b0;
      done = 1'b0;
      if (i == 0) begin
        #1;
        check({tag, " R3 first word next cycle"}, {valid_o, ctrl_o, dout_o[30:0]},
              {1'b1, 1'b0, w[0][30:0]});
      end
      if (i != n - 1) for (int g = 0; g < gap; g++) begin @(negedge clk); p++; end
    end
    if (!done_last) begin
      for (int t = 0; t < tail; t++) begin @(negedge clk); p++; end
      done = 1'b1;
      @(negedge clk);
      p++;
      done = 1'b0;
    end
    repeat (8) @(negedge clk);
    err = '0;
    lat = 2 + p;
    if (lat > 65535) lat = 65535;
    check({tag, " R3 word count"}, 33'(got.size()), 33'(n + 3));
    if (got.size() == n + 3) begin
      check({tag, " R1 R10 header1"}, got[0], hdr1());
      check({tag, " R2 R5 header2"}, got[1], {1'b1, prev_exp, 16'd1});
      for (int i = 0; i < n; i++) check({tag, " R3 R6 data"}, got[2 + i], {1'b0, w[i]});
      check({tag, " R4 R6 R11 trailer"}, got[n + 2], {1'b1, 16'(n), e, 1'b0});
    end
    prev_exp = 16'(lat);
  endtask

  task automatic t_reset();
    check("R3 valid low after reset", 33'(valid_o), 33'd0);
  endtask

  task automatic t_overflow();
    logic [32:0] held;
    ready = 1'b0;
    open_event();
    for (int i = 0; i < 4; i++) begin
      din_valid = 1'b1;
      din = 32'hC0DE_0000 + 32'(i);
      @(negedge clk);
    end
    din_valid = 1'b0;
    #1 held = {ctrl_o, dout_o};
    check("R7 stall holds header1", held, hdr1());
    check("R7 valid during stall", 33'(valid_o), 33'd1);
    ready = 1'b1;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    repeat (8) @(negedge clk);
    check("R8 overflow word count", 33'(got.size()), 33'd5);
    if (got.size() == 5) begin
      check("R7 kept word 0", got[2], {1'b0, 32'hC0DE_0000});
      check("R7 kept word 1", got[3], {1'b0, 32'hC0DE_0001});
      check("R8 trailer size and flag", got[4], {1'b1, 16'd2, 15'd0, 1'b1});
    end
    prev_exp = 16'd7;
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; accept = 0; bx = 0; done = 0; din_valid = 0; din = '0;
    ready = 1'b1; err = '0;
    fmt_ver = 8'h5C; src_id = 4'h9; region = 2'd2; buf_num = 2'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    pulse_bx(3);
    run_event(3, 0, 0, 1'b0, 15'h0000, "basic");        // R5 prev=0 after reset
    fmt_ver = 8'hE1; src_id = 4'h3; region = 2'd1; buf_num = 2'd3;
    pulse_bx(300);                                        // R10 wrap
    run_event(4, 2, 0, 1'b1, 15'h1234, "gaps_done_last"); // R11
    run_event(0, 0, 1, 1'b0, 15'h7FFF, "empty");          // R4
    t_overflow();
    run_event(2, 0, 0, 1'b1, 15'h0001, "after_ovf");      // R8 cleared, R5 prev=7
    run_event(1, 0, 70000, 1'b0, 15'h0000, "long");       // R9
    run_event(1, 0, 0, 1'b1, 15'h0000, "sat_prev");       // R9 prev=0xFFFF
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule